// File: doc/BRIEF.md
# Protection Region Attribute Bank and Access Checker

This block keeps the per-region attributes of an eight-region memory protection unit and judges every access against them. Software-side writes arrive as a register number, a 3-bit secondary selector (op2) and a 32-bit data word. They load one of five attribute sets:

- cacheable flags for the data side;
- cacheable flags for the instruction side;
- bufferable flags, which exist for the data side only;
- a 2-bit permission code per region for the data side;
- a 2-bit permission code per region for the instruction side.

The access checker is purely combinational. It takes a region index, an instruction/data selector, a privilege flag and a read/write flag. It returns an abort decision together with the cacheable and bufferable attributes that apply to that access. An address-to-region match happens upstream and is not part of this block.

Top module: `mpu_attr_unit`

## Requirements
- R1: A write with register number 2 loads `wr_data[7:0]` into the cacheable flags, with bit n belonging to region n. It loads the data-side set when op2 is 0 and the instruction-side set when op2 is 1. `chk_cacheable` reports the flag of the selected side and region.
- R2: A write with register number 3 and op2 equal to 0 loads `wr_data[7:0]` into the data-side bufferable flags, with bit n belonging to region n. `chk_bufferable` reports that flag for data accesses and is always 0 for instruction fetches.
- R3: A write with register number 5 loads `wr_data[15:0]` into the permissions. It loads the data-side set when op2 is 0 and the instruction-side set when op2 is 1. Region n uses bits [2n+1:2n]. Code 00 aborts every access.
- R4: Code 01 lets privileged accesses through and aborts every user access.
- R5: Code 10 lets privileged reads and writes through, lets user reads through and aborts user writes.
- R6: Code 11 never aborts.
- R7: An instruction fetch is judged as a read, whatever the value of `chk_write`.
- R8: The following writes change no attribute: register 3 with a nonzero op2, register 2 or 5 with op2 above 1, and any register number other than 2, 3 or 5. For such a write, `wr_invalid` is high for exactly the one cycle after the write edge. It is low at every other time.
- R9: The checker outputs depend combinationally on the current attribute contents. A write sampled at one clock edge is reflected in the checker outputs straight after that edge.
- R10: Synchronous active-low reset clears every flag and permission. After reset every access aborts, reports cacheable 0 and bufferable 0, and `wr_invalid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Attribute write strobe |
| wr_reg | input | 4 | Target register number |
| wr_op2 | input | 3 | Secondary selector (data/instruction set) |
| wr_data | input | 32 | Write data |
| wr_invalid | output | 1 | One-cycle flag raised after an ignored write |
| chk_region | input | 3 | Region index of the access |
| chk_instr | input | 1 | 1 = instruction fetch, 0 = data access |
| chk_priv | input | 1 | 1 = privileged mode |
| chk_write | input | 1 | 1 = write access |
| chk_abort | output | 1 | Access denied |
| chk_cacheable | output | 1 | Cacheable attribute for the access |
| chk_bufferable | output | 1 | Bufferable attribute for the access |

## Verification
A corrupt attribute bit shows up at the ports as soon as an access names the region and side it belongs to. It appears there as a wrong abort, cacheable or bufferable value, with no latency, because the checker is combinational. The bench therefore sweeps all 64 combinations of region, side, mode and direction after every write. Any bit that is mis-steered, aliased between sides or disturbed by an ignored write shows up within one sweep. A wrong write decode also shows on `wr_invalid` in the single cycle after the write.

// File: rtl/mpu_attr_pkg.sv
// Shared constants and types for the protection attribute block.
// Assumes register numbers are compared after zero-extension to the port width.
package mpu_attr_pkg;

    // Register numbers that carry attributes
    localparam int CRN_CACHE = 2;
    localparam int CRN_BUFF  = 3;
    localparam int CRN_PERM  = 5;

    // op2 values that select the data or instruction set
    localparam int SEL_DATA  = 0;
    localparam int SEL_INSTR = 1;

    // Two-bit permission codes
    typedef enum logic [1:0] {
        PERM_NONE    = 2'b00,
        PERM_PRIV    = 2'b01,
        PERM_USER_RO = 2'b10,
        PERM_FULL    = 2'b11
    } perm_code_e;

endpackage

// File: rtl/mpu_attr_regs.sv
// Attribute register bank: decodes (register, op2, data) writes into five
// attribute sets and flags writes that fall outside the supported map.
// Assumes DATA_W >= 2*NUM_REGIONS. Writes take effect at the clock edge.
module mpu_attr_regs
    import mpu_attr_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int DATA_W      = 32,
    parameter int REG_W       = 4,
    parameter int OP2_W       = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [REG_W-1:0]         wr_reg,
    input  logic [OP2_W-1:0]         wr_op2,
    input  logic [DATA_W-1:0]        wr_data,
    output logic                     wr_invalid,
    output logic [NUM_REGIONS-1:0]   d_cache,
    output logic [NUM_REGIONS-1:0]   i_cache,
    output logic [NUM_REGIONS-1:0]   d_buf,
    output logic [2*NUM_REGIONS-1:0] d_perm,
    output logic [2*NUM_REGIONS-1:0] i_perm
);
    localparam int PERM_W = 2 * NUM_REGIONS;
    localparam logic [REG_W-1:0] RN_CACHE = REG_W'(CRN_CACHE);
    localparam logic [REG_W-1:0] RN_BUFF  = REG_W'(CRN_BUFF);
    localparam logic [REG_W-1:0] RN_PERM  = REG_W'(CRN_PERM);
    localparam logic [OP2_W-1:0] OP_DATA  = OP2_W'(SEL_DATA);
    localparam logic [OP2_W-1:0] OP_INSTR = OP2_W'(SEL_INSTR);

    logic hit_c2d, hit_c2i, hit_c3d, hit_c5d, hit_c5i, wr_ok;
    logic unused_hi;

    // Upper data bits carry no attribute
    assign unused_hi = ^wr_data[DATA_W-1:PERM_W];

    // Write decode: which attribute set, if any, a write targets
    always_comb begin
        hit_c2d = wr_en && (wr_reg == RN_CACHE) && (wr_op2 == OP_DATA);
        hit_c2i = wr_en && (wr_reg == RN_CACHE) && (wr_op2 == OP_INSTR);
        hit_c3d = wr_en && (wr_reg == RN_BUFF)  && (wr_op2 == OP_DATA);
        hit_c5d = wr_en && (wr_reg == RN_PERM)  && (wr_op2 == OP_DATA);
        hit_c5i = wr_en && (wr_reg == RN_PERM)  && (wr_op2 == OP_INSTR);
        wr_ok   = hit_c2d || hit_c2i || hit_c3d || hit_c5d || hit_c5i;
    end

    // Attribute storage, cleared to non-cacheable / no-access by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_cache <= '0;
            i_cache <= '0;
            d_buf   <= '0;
            d_perm  <= '0;
            i_perm  <= '0;
        end else begin
            if (hit_c2d) d_cache <= wr_data[NUM_REGIONS-1:0];
            if (hit_c2i) i_cache <= wr_data[NUM_REGIONS-1:0];
            if (hit_c3d) d_buf   <= wr_data[NUM_REGIONS-1:0];
            if (hit_c5d) d_perm  <= wr_data[PERM_W-1:0];
            if (hit_c5i) i_perm  <= wr_data[PERM_W-1:0];
        end
    end

    // One-cycle flag for a write that matched no supported set
    always_ff @(posedge clk) begin
        if (!rst_n) wr_invalid <= 1'b0;
        else        wr_invalid <= wr_en && !wr_ok;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> ({d_cache, i_cache, d_buf, d_perm, i_perm} == '0 && !wr_invalid)); // R10
    AST_BAD_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && !wr_ok) |-> ($stable({d_cache, i_cache, d_buf, d_perm, i_perm}) && wr_invalid)); // R8
    AST_GOOD_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!(wr_en && !wr_ok)) |-> !wr_invalid); // R8
    AST_DCACHE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hit_c2d) |-> (d_cache == $past(wr_data[NUM_REGIONS-1:0]))); // R1
    AST_BUF_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hit_c3d) |-> (d_buf == $past(wr_data[NUM_REGIONS-1:0]))); // R2
    AST_IPERM_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hit_c5i) |-> (i_perm == $past(wr_data[PERM_W-1:0]))); // R3

endmodule

// File: rtl/mpu_perm_check.sv
// Combinational access checker: evaluates the permission code of every
// region for the current mode and direction, then selects the addressed one.
// Assumes NUM_REGIONS is a power of two so every index is in range.
module mpu_perm_check
    import mpu_attr_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int IDX_W       = 3
) (
    input  logic [NUM_REGIONS-1:0]   d_cache,
    input  logic [NUM_REGIONS-1:0]   i_cache,
    input  logic [NUM_REGIONS-1:0]   d_buf,
    input  logic [2*NUM_REGIONS-1:0] d_perm,
    input  logic [2*NUM_REGIONS-1:0] i_perm,
    input  logic [IDX_W-1:0]         region,
    input  logic                     instr,
    input  logic                     priv,
    input  logic                     write,
    output logic                     abort,
    output logic                     cacheable,
    output logic                     bufferable
);
    logic [NUM_REGIONS-1:0] region_abort;
    logic                   eff_write;

    // Instruction fetches are judged as reads
    assign eff_write = write && !instr;

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
        perm_code_e code;

        // Per-region permission decode for the side selected by instr
        always_comb begin
            code = perm_code_e'(instr ? i_perm[2*g +: 2] : d_perm[2*g +: 2]);
            unique case (code)
                PERM_NONE:    region_abort[g] = 1'b1;
                PERM_PRIV:    region_abort[g] = !priv;
                PERM_USER_RO: region_abort[g] = !priv && eff_write;
                PERM_FULL:    region_abort[g] = 1'b0;
                default:      region_abort[g] = 1'b1;
            endcase
        end
    end

    // Select the addressed region's decision and attributes
    always_comb begin
        abort      = region_abort[region];
        cacheable  = instr ? i_cache[region] : d_cache[region];
        bufferable = !instr && d_buf[region];
    end

endmodule

// File: rtl/mpu_attr_unit.sv
// Top of the protection attribute block: register bank plus access checker.
// Assumes the region index is already resolved from the address upstream.
module mpu_attr_unit
    import mpu_attr_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int DATA_W      = 32,
    parameter int REG_W       = 4,
    parameter int OP2_W       = 3,
    localparam int IDX_W      = $clog2(NUM_REGIONS),
    localparam int PERM_W     = 2 * NUM_REGIONS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_reg,
    input  logic [OP2_W-1:0]  wr_op2,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_invalid,
    input  logic [IDX_W-1:0]  chk_region,
    input  logic              chk_instr,
    input  logic              chk_priv,
    input  logic              chk_write,
    output logic              chk_abort,
    output logic              chk_cacheable,
    output logic              chk_bufferable
);
    logic [NUM_REGIONS-1:0] d_cache, i_cache, d_buf;
    logic [PERM_W-1:0]      d_perm, i_perm;
    logic [1:0]             cur_code;

    mpu_attr_regs #(
        .NUM_REGIONS(NUM_REGIONS), .DATA_W(DATA_W), .REG_W(REG_W), .OP2_W(OP2_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_reg(wr_reg),
        .wr_op2(wr_op2), .wr_data(wr_data), .wr_invalid(wr_invalid),
        .d_cache(d_cache), .i_cache(i_cache), .d_buf(d_buf),
        .d_perm(d_perm), .i_perm(i_perm)
    );

    mpu_perm_check #(
        .NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)
    ) u_check (
        .d_cache(d_cache), .i_cache(i_cache), .d_buf(d_buf),
        .d_perm(d_perm), .i_perm(i_perm), .region(chk_region),
        .instr(chk_instr), .priv(chk_priv), .write(chk_write),
        .abort(chk_abort), .cacheable(chk_cacheable), .bufferable(chk_bufferable)
    );

    // Code of the addressed region, observed by the checks below
    assign cur_code = chk_instr ? i_perm[{chk_region, 1'b0} +: 2] : d_perm[{chk_region, 1'b0} +: 2];

    AST_NONE_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_code == PERM_NONE) |-> chk_abort); // R3
    AST_PRIV_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_code == PERM_PRIV) |-> (chk_abort == !chk_priv)); // R4
    AST_USER_WRITE_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_code == PERM_USER_RO && !chk_instr) |-> (chk_abort == (!chk_priv && chk_write))); // R5
    AST_FULL_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_code == PERM_FULL) |-> !chk_abort); // R6
    AST_FETCH_IS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_code == PERM_USER_RO && chk_instr) |-> !chk_abort); // R7
    AST_FETCH_NO_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        chk_instr |-> !chk_bufferable); // R2

endmodule

// File: tb/sim_mpu_attr_unit.sv
module sim_mpu_attr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_reg = '0;
    logic [2:0]  wr_op2 = '0;
    logic [31:0] wr_data = '0;
    logic        wr_invalid;
    logic [2:0]  chk_region = '0;
    logic        chk_instr = 1'b0, chk_priv = 1'b0, chk_write = 1'b0;
    logic        chk_abort, chk_cacheable, chk_bufferable;

    int n_checks = 0;
    int n_fail = 0;

    // Bench model of the attribute contents
    logic [7:0]  m_dc = '0, m_ic = '0, m_bf = '0;
    logic [15:0] m_dp = '0, m_ip = '0;

    always #10 clk = ~clk;

    mpu_attr_unit u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_reg(wr_reg), .wr_op2(wr_op2),
        .wr_data(wr_data), .wr_invalid(wr_invalid), .chk_region(chk_region),
        .chk_instr(chk_instr), .chk_priv(chk_priv), .chk_write(chk_write),
        .chk_abort(chk_abort), .chk_cacheable(chk_cacheable), .chk_bufferable(chk_bufferable)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Write one attribute register; R8 checks on the flag, R9 via later sweep
    task automatic wr(input int rn, input int op, input logic [31:0] d);
        bit ok;
        @(negedge clk);
        wr_en = 1'b1; wr_reg = 4'(rn); wr_op2 = 3'(op); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        ok = (rn == 2 && op <= 1) || (rn == 3 && op == 0) || (rn == 5 && op <= 1);
        check(wr_invalid == !ok, "R8 flag after write", int'(wr_invalid), int'(!ok));
        if (rn == 2 && op == 0) m_dc = d[7:0];
        if (rn == 2 && op == 1) m_ic = d[7:0];
        if (rn == 3 && op == 0) m_bf = d[7:0];
        if (rn == 5 && op == 0) m_dp = d[15:0];
        if (rn == 5 && op == 1) m_ip = d[15:0];
        @(negedge clk);
        check(wr_invalid == 1'b0, "R8 flag one cycle", int'(wr_invalid), 0);
    endtask

    // Sweep all region/side/mode/direction combinations against the model
    task automatic sweep(input string tag);
        for (int i = 0; i < 64; i++) begin
            int r, code;
            bit ins, pv, w, we, ea, ec, eb;
            string rq;
            r = i % 8; ins = i[3]; pv = i[4]; w = i[5];
            chk_region = 3'(r); chk_instr = ins; chk_priv = pv; chk_write = w;
            #1;
            code = ins ? int'((m_ip >> (2 * r)) & 16'h3) : int'((m_dp >> (2 * r)) & 16'h3);
            we = w && !ins;
            ea = (code == 0) || (code == 1 && !pv) || (code == 2 && !pv && we);
            ec = ins ? m_ic[r] : m_dc[r];
            eb = !ins && m_bf[r];
            case (code)
                0: rq = "R3";
                1: rq = "R4";
                2: rq = "R5";
                default: rq = "R6";
            endcase
            if (ins && w) rq = {rq, " R7"};
            check(chk_abort == ea, {tag, " abort ", rq, " R9"}, int'(chk_abort), int'(ea));
            check(chk_cacheable == ec, {tag, " cacheable R1"}, int'(chk_cacheable), int'(ec));
            check(chk_bufferable == eb, {tag, " bufferable R2"}, int'(chk_bufferable), int'(eb));
        end
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(wr_invalid == 1'b0, "R10 flag after reset", int'(wr_invalid), 0);
        sweep("R10 reset");

        wr(2, 0, 32'hFFFF_FF1A);
        wr(2, 1, 32'h0000_0012);
        wr(3, 0, 32'h5555_5508);
        wr(5, 0, 32'hABCD_E4E4);
        wr(5, 1, 32'h0000_1B1B);
        sweep("mixed");

        // Ignored writes must leave every attribute untouched
        wr(3, 1, 32'hFFFF_FFFF);
        wr(7, 0, 32'hFFFF_FFFF);
        wr(2, 2, 32'hFFFF_FFFF);
        wr(5, 5, 32'hFFFF_FFFF);
        wr(0, 0, 32'h0000_0000);
        sweep("R8 after ignored");

        wr(5, 0, 32'h0000_AAAA);
        wr(5, 1, 32'h0000_5555);
        wr(3, 0, 32'h0000_00F0);
        sweep("user-ro/priv");

        wr(5, 0, 32'h0000_FFFF);
        wr(5, 1, 32'h0000_0000);
        wr(2, 0, 32'h0000_0081);
        wr(2, 1, 32'h0000_007E);
        sweep("full/none");

        wr(5, 1, 32'hFFFF_39C6);
        wr(5, 0, 32'h0000_6C93);
        sweep("scattered");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule